// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block turns an asynchronous serial line into parallel characters. A separate receive clock runs at 1, 16 or 64 times the bit rate. The block synchronizes that clock and the serial line into the system clock domain, and the rising edges of the receive clock act as sampling ticks. In the oversampled rates, a falling edge on the line starts a mid-bit check of the start bit. The block then takes each data bit, the optional parity bit and the stop bit at its centre.

Each completed character goes into a holding register and raises a ready flag. A one-cycle read pulse takes the character and drops the flag. Parity, overrun and framing errors stay set until a clear pulse arrives. A break output reports a line that stays low through the stop positions of two characters in a row, and it drops when the line goes high again.

Top module: `async_rx_core`

## Requirements
- R1: `rateSel` picks the oversampling rate: 0 = 1 tick per bit (line sampled on every receive-clock rising edge), 1 = 16 ticks per bit, 2 or 3 = 64 ticks per bit.
- R2: At 16 or 64 ticks per bit, the start bit is taken again 8 or 32 ticks after the tick that first saw the line low. If the line is high at that point, the start is dropped and the receiver waits for the line to go low again. After an accepted start, every later bit is sampled 16 or 64 ticks after the one before it.
- R3: `charLen` 0,1,2,3 selects 5,6,7,8 data bits, least significant bit first. The character is right-justified in `rxData`, and the unused upper bits read 0.
- R4: `rxReady` rises when a character is loaded. It is low one clock after a `readStrobe` pulse, unless a new character loads in that same clock.
- R5: When `parityEn` is set, one parity bit follows the data. With `parityEven` = 1 the data bits and the parity bit together hold an even number of ones; with 0, an odd number. A mismatch sets `parityErr` when the character loads.
- R6: A low stop-bit sample sets `frameErr`. The character is still loaded.
- R7: If a character loads while `rxReady` is still set and no read happens in that clock, the new character replaces the old one and `overrunErr` is set.
- R8: `breakDet` goes high when two characters in a row are all low, stop bit included. It goes low once the synchronized line is high.
- R9: The three error flags stay set until an `errClear` pulse. If a new error arrives in the same clock as the clear, the new error stays set.
- R10: While `rxEnable` is low, the line is ignored, the receiver returns to idle and `rxReady` is held low.
- R11: After reset, `rxReady`, all error flags, `breakDet` and `rxData` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rxClk | input | 1 | Receive sampling clock, asynchronous to clk |
| rxd | input | 1 | Serial line, idle high |
| rxEnable | input | 1 | Receive enable |
| rateSel | input | 2 | Oversampling rate select |
| charLen | input | 2 | Data bit count select |
| parityEn | input | 1 | Parity bit present |
| parityEven | input | 1 | Even parity when 1, odd when 0 |
| readStrobe | input | 1 | One-cycle pulse: character taken |
| errClear | input | 1 | One-cycle pulse: clear error flags |
| rxData | output | 8 | Holding register |
| rxReady | output | 1 | Character waiting |
| parityErr | output | 1 | Sticky parity error |
| overrunErr | output | 1 | Sticky overrun error |
| frameErr | output | 1 | Sticky framing error |
| breakDet | output | 1 | Break on the line |

## Verification
The properties assume that `rxClk` and `rxd` change slowly compared with `clk`, so that each receive-clock level lasts for several system clocks after synchronization. They also assume that the configuration inputs do not change in the middle of a character. The stimulus holds each `rxClk` level for two system clocks. It changes `rxd` only while `rxClk` is low, and it reprograms rate, length and parity only while the line is idle. Read and clear pulses are one system clock wide.

// File: rtl/arx_pkg.sv
package arx_pkg;
  localparam int DATA_W  = 8;
  localparam int OVS_MAX = 64;
  localparam int CNT_W   = $clog2(OVS_MAX);
  localparam int IDX_W   = $clog2(DATA_W);

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_STOP
  } rxState_t;

  typedef struct packed {
    logic frameStart;
    logic dataBit;
    logic parityBit;
    logic stopBit;
  } rxStrobe_t;

  function automatic logic [CNT_W-1:0] bitReload(input logic [1:0] rate);
    case (rate)
      2'd0:    return '0;
      2'd1:    return CNT_W'(15);
      default: return CNT_W'(OVS_MAX - 1);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] halfReload(input logic [1:0] rate);
    return (rate == 2'd1) ? CNT_W'(7) : CNT_W'(OVS_MAX / 2 - 1);
  endfunction
endpackage

// File: rtl/arx_sync.sv
module arx_sync #(
  parameter int STAGES = 2,
  parameter logic INIT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{INIT}};
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/arx_ctrl.sv
module arx_ctrl
  import arx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rxEnable,
  input  logic             tick,
  input  logic             lineBit,
  input  logic [1:0]       rateSel,
  input  logic [1:0]       charLen,
  input  logic             parityEn,
  output rxStrobe_t        strobe,
  output logic [IDX_W-1:0] bitIdx
);
  rxState_t         state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] lastIdx;
  logic             sampleNow;
  logic             singleRate;

  assign lastIdx    = IDX_W'(4) + IDX_W'(charLen);
  assign sampleNow  = tick && (cnt == '0);
  assign singleRate = (rateSel == 2'd0);

  always_ff @(posedge clk) begin
    if (rst || !rxEnable) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else if (tick) begin
      case (state)
        ST_IDLE: begin
          if (!lineBit) begin
            bitIdx <= '0;
            if (singleRate) begin
              state <= ST_DATA;
              cnt   <= '0;
            end else begin
              state <= ST_START;
              cnt   <= halfReload(rateSel);
            end
          end
        end
        ST_START: begin
          if (cnt == '0) begin
            if (lineBit) begin
              state <= ST_IDLE;
            end else begin
              state <= ST_DATA;
              cnt   <= bitReload(rateSel);
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_DATA: begin
          if (cnt == '0) begin
            cnt <= bitReload(rateSel);
            if (bitIdx == lastIdx) state <= parityEn ? ST_PARITY : ST_STOP;
            else                   bitIdx <= bitIdx + 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_PARITY: begin
          if (cnt == '0) begin
            state <= ST_STOP;
            cnt   <= bitReload(rateSel);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_STOP: begin
          if (cnt == '0) state <= ST_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.frameStart = rxEnable && tick && (state == ST_IDLE) && !lineBit;
    strobe.dataBit    = rxEnable && sampleNow && (state == ST_DATA);
    strobe.parityBit  = rxEnable && sampleNow && (state == ST_PARITY);
    strobe.stopBit    = rxEnable && sampleNow && (state == ST_STOP);
  end
endmodule

// File: rtl/arx_datapath.sv
module arx_datapath
  import arx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rxEnable,
  input  logic              lineBit,
  input  rxStrobe_t         strobe,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic              parityEn,
  input  logic              parityEven,
  input  logic              readStrobe,
  input  logic              errClear,
  output logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  output logic              parityErr,
  output logic              overrunErr,
  output logic              frameErr,
  output logic              breakDet
);
  logic [DATA_W-1:0] shiftReg;
  logic              parRx;
  logic              allLow;
  logic              prevBreak;
  logic              parMiss;
  logic              breakFrame;

  assign parMiss    = parityEn && ((^shiftReg) ^ parRx ^ ~parityEven);
  assign breakFrame = strobe.stopBit && !lineBit && allLow;

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      parRx    <= 1'b0;
      allLow   <= 1'b0;
    end else if (strobe.frameStart) begin
      shiftReg <= '0;
      parRx    <= 1'b0;
      allLow   <= 1'b1;
    end else begin
      if (strobe.dataBit)  shiftReg[bitIdx] <= lineBit;
      if (strobe.parityBit) parRx <= lineBit;
      if ((strobe.dataBit || strobe.parityBit) && lineBit) allLow <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxData  <= '0;
      rxReady <= 1'b0;
    end else begin
      if (strobe.stopBit) rxData <= shiftReg;
      if (!rxEnable)           rxReady <= 1'b0;
      else if (strobe.stopBit) rxReady <= 1'b1;
      else if (readStrobe)     rxReady <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      parityErr  <= 1'b0;
      overrunErr <= 1'b0;
      frameErr   <= 1'b0;
    end else begin
      parityErr  <= (parityErr  && !errClear) || (strobe.stopBit && parMiss);
      overrunErr <= (overrunErr && !errClear) ||
                    (strobe.stopBit && rxReady && !readStrobe);
      frameErr   <= (frameErr   && !errClear) || (strobe.stopBit && !lineBit);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      breakDet  <= 1'b0;
      prevBreak <= 1'b0;
    end else if (lineBit) begin
      breakDet  <= 1'b0;
      prevBreak <= 1'b0;
    end else if (strobe.stopBit) begin
      prevBreak <= breakFrame;
      if (breakFrame && prevBreak) breakDet <= 1'b1;
    end
  end
endmodule

// File: rtl/async_rx_core.sv
module async_rx_core
  import arx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxClk,
  input  logic              rxd,
  input  logic              rxEnable,
  input  logic [1:0]        rateSel,
  input  logic [1:0]        charLen,
  input  logic              parityEn,
  input  logic              parityEven,
  input  logic              readStrobe,
  input  logic              errClear,
  output logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  output logic              parityErr,
  output logic              overrunErr,
  output logic              frameErr,
  output logic              breakDet
);
  logic             clkSync;
  logic             clkPrev;
  logic             tick;
  logic             lineSync;
  logic             rxLoad;
  rxStrobe_t        strobe;
  logic [IDX_W-1:0] bitIdx;

  arx_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_clkSync (
    .clk(clk), .rst(rst), .din(rxClk), .dout(clkSync));

  arx_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_lineSync (
    .clk(clk), .rst(rst), .din(rxd), .dout(lineSync));

  always_ff @(posedge clk) begin
    if (rst) clkPrev <= 1'b0;
    else     clkPrev <= clkSync;
  end

  assign tick   = clkSync && !clkPrev;
  assign rxLoad = strobe.stopBit;

  arx_ctrl u_ctrl (
    .clk(clk), .rst(rst), .rxEnable(rxEnable), .tick(tick),
    .lineBit(lineSync), .rateSel(rateSel), .charLen(charLen),
    .parityEn(parityEn), .strobe(strobe), .bitIdx(bitIdx));

  arx_datapath u_dp (
    .clk(clk), .rst(rst), .rxEnable(rxEnable), .lineBit(lineSync),
    .strobe(strobe), .bitIdx(bitIdx), .parityEn(parityEn),
    .parityEven(parityEven), .readStrobe(readStrobe), .errClear(errClear),
    .rxData(rxData), .rxReady(rxReady), .parityErr(parityErr),
    .overrunErr(overrunErr), .frameErr(frameErr), .breakDet(breakDet));
endmodule

// File: rtl/async_rx_checker.sv
module async_rx_checker (
  input logic clk,
  input logic rst,
  input logic rxEnable,
  input logic readStrobe,
  input logic errClear,
  input logic rxLoad,
  input logic lineSync,
  input logic rxReady,
  input logic parityErr,
  input logic overrunErr,
  input logic frameErr,
  input logic breakDet
);
  a_r4_read_drops: assert property (@(posedge clk) disable iff (rst)
    readStrobe && !rxLoad |=> !rxReady);

  a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    !rxEnable |=> !rxReady);

  a_r10_load_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(rxReady) |-> $past(rxEnable));

  a_r8_break_with_framing: assert property (@(posedge clk) disable iff (rst)
    $rose(breakDet) |-> frameErr);

  a_r8_break_release: assert property (@(posedge clk) disable iff (rst)
    lineSync |=> !breakDet);

  a_r9_flags_sticky: assert property (@(posedge clk) disable iff (rst)
    ($fell(parityErr) || $fell(overrunErr) || $fell(frameErr)) |-> $past(errClear));
endmodule

bind async_rx_core async_rx_checker u_chk (
  .clk(clk), .rst(rst), .rxEnable(rxEnable), .readStrobe(readStrobe),
  .errClear(errClear), .rxLoad(rxLoad), .lineSync(lineSync),
  .rxReady(rxReady), .parityErr(parityErr), .overrunErr(overrunErr),
  .frameErr(frameErr), .breakDet(breakDet));

// File: tb/async_rx_core_bench.sv
module async_rx_core_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxClk = 1'b0;
  logic       rxd = 1'b1;
  logic       rxEnable = 1'b1;
  logic [1:0] rateSel = 2'd1;
  logic [1:0] charLen = 2'd3;
  logic       parityEn = 1'b0;
  logic       parityEven = 1'b0;
  logic       readStrobe = 1'b0;
  logic       errClear = 1'b0;
  logic [7:0] rxData;
  logic       rxReady, parityErr, overrunErr, frameErr, breakDet;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 0;

  always #2.5 clk = ~clk;

  async_rx_core u_async_rx_core (
    .clk(clk), .rst(rst), .rxClk(rxClk), .rxd(rxd), .rxEnable(rxEnable),
    .rateSel(rateSel), .charLen(charLen), .parityEn(parityEn),
    .parityEven(parityEven), .readStrobe(readStrobe), .errClear(errClear),
    .rxData(rxData), .rxReady(rxReady), .parityErr(parityErr),
    .overrunErr(overrunErr), .frameErr(frameErr), .breakDet(breakDet));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tickBit(input logic b);
    rxd = b;
    repeat (2) @(negedge clk);
    rxClk = 1'b1;
    repeat (2) @(negedge clk);
    rxClk = 1'b0;
  endtask

  task automatic holdLine(input logic b, input int n);
    for (int i = 0; i < n; i++) tickBit(b);
  endtask

  function automatic int ovs(input logic [1:0] r);
    return (r == 2'd0) ? 1 : (r == 2'd1) ? 16 : 64;
  endfunction

  task automatic sendChar(input logic [7:0] data, input logic badPar, input logic stopVal);
    int   n = ovs(rateSel);
    int   len = 5 + int'(charLen);
    logic p = 1'b0;
    holdLine(1'b0, n);
    for (int i = 0; i < len; i++) begin
      holdLine(data[i], n);
      p ^= data[i];
    end
    if (parityEn) holdLine(p ^ ~parityEven ^ badPar, n);
    holdLine(stopVal, n);
    holdLine(1'b1, 2);
  endtask

  task automatic pulseRead();
    @(negedge clk) readStrobe = 1'b1;
    @(negedge clk) readStrobe = 1'b0;
  endtask

  task automatic pulseClear();
    @(negedge clk) errClear = 1'b1;
    @(negedge clk) errClear = 1'b0;
  endtask

  task automatic tReset();
    chk("R11 ready", rxReady, 0);
    chk("R11 flags", {parityErr, overrunErr, frameErr}, 0);
    chk("R11 break", breakDet, 0);
    chk("R11 data", rxData, 0);
  endtask

  task automatic tBasic();
    rateSel = 2'd1; charLen = 2'd3; parityEn = 1'b0;
    sendChar(8'hA5, 1'b0, 1'b1);
    chk("R4 ready after load", rxReady, 1);
    chk("R1 x16 data", rxData, 8'hA5);
    pulseRead();
    @(negedge clk);
    chk("R4 ready after read", rxReady, 0);
    chk("R6 clean stop", frameErr, 0);
  endtask

  task automatic tLengths();
    rateSel = 2'd0; charLen = 2'd0;
    sendChar(8'hF3, 1'b0, 1'b1);
    chk("R3 x1 five bits right-justified", rxData, 8'h13);
    pulseRead();
    rateSel = 2'd2; charLen = 2'd1;
    sendChar(8'hEA, 1'b0, 1'b1);
    chk("R1 x64 six bits", rxData, 8'h2A);
    pulseRead();
    rateSel = 2'd1; charLen = 2'd2;
  endtask

  task automatic tParity();
    rateSel = 2'd1; charLen = 2'd2; parityEn = 1'b1; parityEven = 1'b1;
    sendChar(8'h35, 1'b0, 1'b1);
    chk("R5 even good", parityErr, 0);
    chk("R5 data with parity", rxData, 8'h35);
    pulseRead();
    parityEven = 1'b0;
    sendChar(8'h35, 1'b0, 1'b1);
    chk("R5 odd good", parityErr, 0);
    pulseRead();
    sendChar(8'h35, 1'b1, 1'b1);
    chk("R5 odd bad", parityErr, 1);
    pulseRead();
    sendChar(8'h11, 1'b0, 1'b1);
    chk("R9 parity sticky", parityErr, 1);
    pulseRead();
    pulseClear();
    @(negedge clk);
    chk("R9 parity cleared", parityErr, 0);
    parityEn = 1'b0;
  endtask

  task automatic tFrame();
    charLen = 2'd3;
    sendChar(8'h5C, 1'b0, 1'b0);
    chk("R6 framing set", frameErr, 1);
    chk("R6 still loaded", rxData, 8'h5C);
    pulseRead();
    sendChar(8'h01, 1'b0, 1'b1);
    chk("R9 framing sticky", frameErr, 1);
    pulseRead();
    pulseClear();
    @(negedge clk);
    chk("R9 framing cleared", frameErr, 0);
  endtask

  task automatic tOverrun();
    sendChar(8'h11, 1'b0, 1'b1);
    chk("R7 no overrun yet", overrunErr, 0);
    sendChar(8'h22, 1'b0, 1'b1);
    chk("R7 overrun set", overrunErr, 1);
    chk("R7 newest kept", rxData, 8'h22);
    pulseRead();
    pulseClear();
    @(negedge clk);
    chk("R9 overrun cleared", overrunErr, 0);
  endtask

  task automatic tGlitch();
    holdLine(1'b0, 4);
    holdLine(1'b1, 40);
    chk("R2 glitch rejected", rxReady, 0);
    sendChar(8'h96, 1'b0, 1'b1);
    chk("R2 next char aligned", rxData, 8'h96);
    chk("R2 no framing after glitch", frameErr, 0);
    pulseRead();
  endtask

  task automatic tDisable();
    rxEnable = 1'b0;
    sendChar(8'h3C, 1'b0, 1'b1);
    chk("R10 disabled no ready", rxReady, 0);
    chk("R10 holding untouched", rxData, 8'h96);
    rxEnable = 1'b1;
    sendChar(8'h3C, 1'b0, 1'b1);
    chk("R10 re-enabled", rxData, 8'h3C);
    pulseRead();
  endtask

  task automatic tBreak();
    holdLine(1'b0, 200);
    chk("R8 one frame not a break", breakDet, 0);
    holdLine(1'b0, 200);
    chk("R8 break set", breakDet, 1);
    chk("R6 break frame framing", frameErr, 1);
    holdLine(1'b1, 2);
    chk("R8 break released", breakDet, 0);
    pulseRead();
    pulseClear();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    tReset();
    tBasic();
    tLengths();
    tParity();
    tFrame();
    tOverrun();
    tGlitch();
    tDisable();
    tBreak();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule